// File: doc/BRIEF.md
# Descriptor-Driven Video Timing Generator

This block produces raster timing (horizontal sync, vertical sync, data-enable and pixel/line coordinates) from a packed 20-byte detailed timing descriptor rather than from fixed parameters. Software or a boot sequencer writes the descriptor one byte at a time through a valid/ready byte port while the generator is stopped. A `start` pulse then checks the descriptor. If it is acceptable, both counters run on the pixel clock. A `stop` pulse halts them and returns them to the origin.

The descriptor holds a 24-bit pixel rate, a flags byte, and four little-endian 16-bit fields for each axis: active count, blank count, front porch and sync width. The top bit of each front-porch field carries the sync polarity for that axis. Each line and each frame begins with its active region. Sync begins after the active region plus the front porch and lasts for the sync width. The rest of the blank is back porch. The pixel rate is only reported; it plays no part in timing.

Back-pressure on the byte port: `cfg_ready` is high exactly while the generator is stopped. A byte transfers on a clock edge where `cfg_valid` and `cfg_ready` are both high. While `cfg_ready` is low, offered bytes are not taken and the held descriptor does not change. Addresses 20 to 31 are dropped.

Top module: `desc_timing_gen`

## Requirements
- R1: `cfg_ready` equals the inverse of `running`. A byte offered while running leaves the descriptor and `pixel_rate_khz` unchanged.
- R2: `pixel_rate_khz` is {byte 2, byte 1, byte 0}. `preferred` is byte 3 bit 7.
- R3: A `start` pulse while stopped, with an acceptable descriptor, raises `running` on the next edge. The first running cycle shows `pix_x` = 0 and `line_y` = 0.
- R4: `pix_x` counts 0 up to hact+hblank−1 and wraps. `line_y` advances by one on each wrap and wraps after vact+vblank lines. hact is bytes 4–5, hblank bytes 6–7, vact bytes 12–13, vblank bytes 14–15, all little-endian.
- R5: `hsync` is at its active level when hact+hfp ≤ `pix_x` < hact+hfp+hsw, and at the inactive level otherwise. hfp is bits 14:0 of bytes 8–9 and hsw is bytes 10–11. The active level is high when byte 9 bit 7 is 1 and low when it is 0.
- R6: `vsync` follows the same rule on `line_y`. vfp is bits 14:0 of bytes 16–17, vsw is bytes 18–19, and the polarity is byte 17 bit 7.
- R7: `de` is high exactly when running with `pix_x` < hact and `line_y` < vact.
- R8: `start` with a descriptor that is interlaced (byte 3 bit 4 = 1), has an active count of zero, or has front porch plus sync width greater than blank on either axis sets `desc_err` and leaves the generator stopped. Front porch plus sync width equal to blank is accepted.
- R9: A `stop` pulse while running stops the generator on the next edge. While stopped, `de` = 0, both syncs are at their inactive level and the coordinates are 0.
- R10: A start that is accepted clears `desc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Descriptor byte offered |
| cfg_ready | output | 1 | Byte port can accept (generator stopped) |
| cfg_addr | input | 5 | Byte offset within descriptor, 0 to 19 |
| cfg_data | input | 8 | Descriptor byte |
| start | input | 1 | Check descriptor and start counting |
| stop | input | 1 | Halt and return to origin |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Active video data-enable |
| pix_x | output | 16 | Pixel position in line, from zero |
| line_y | output | 16 | Line position in frame, from zero |
| running | output | 1 | Counters are running |
| desc_err | output | 1 | Last start attempt was rejected |
| pixel_rate_khz | output | 24 | Pixel rate field from descriptor |
| preferred | output | 1 | Preferred-timing flag from descriptor |

## Verification
Every output is computed directly from the two counter registers and the held descriptor, so a wrong counter value shows up at `pix_x` or `line_y` in the same cycle. A wrong total or wrap condition skews the sync and data-enable windows by the next line or frame. A decode fault, such as a swapped byte or a lost polarity bit, changes an idle sync level or a window edge within one line of starting. A faulty accept or reject decision shows at `running` and `desc_err` one edge after `start`. The bench compares every running cycle against a model built from the requirements. It covers two descriptors: one with both polarities and a back porch, and one with no front porch and no back porch.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int DESC_BYTES = 20;
  localparam int ADDR_W     = 5;
  localparam int CNT_W      = 16;
  localparam int PORCH_W    = CNT_W - 1;
  localparam int RATE_W     = 24;

  typedef struct packed {
    logic [CNT_W-1:0]   act;
    logic [CNT_W-1:0]   blk;
    logic [PORCH_W-1:0] fp;
    logic [CNT_W-1:0]   sw;
    logic               pos;
  } axis_cfg_t;
endpackage

// File: rtl/vtg_desc_store.sv
module vtg_desc_store
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output axis_cfg_t         h_cfg,
  output axis_cfg_t         v_cfg,
  output logic [RATE_W-1:0] rate,
  output logic              preferred,
  output logic              cfg_ok
);
  localparam int SUM_W = CNT_W + 1;

  logic [7:0] mem [DESC_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DESC_BYTES; i++) mem[i] <= 8'h00;
    end else if (wr_en && (int'(wr_addr) < DESC_BYTES)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  function automatic axis_cfg_t unpack_axis(int base);
    axis_cfg_t c;
    c.act = {mem[base+1], mem[base]};
    c.blk = {mem[base+3], mem[base+2]};
    c.fp  = {mem[base+5][6:0], mem[base+4]};
    c.pos = mem[base+5][7];
    c.sw  = {mem[base+7], mem[base+6]};
    return c;
  endfunction

  function automatic logic axis_ok(axis_cfg_t c);
    logic [SUM_W-1:0] need;
    need = SUM_W'(c.fp) + SUM_W'(c.sw);
    return (c.act != '0) && (need <= SUM_W'(c.blk));
  endfunction

  logic interlaced;

  always_comb begin
    h_cfg      = unpack_axis(4);
    v_cfg      = unpack_axis(12);
    rate       = {mem[2], mem[1], mem[0]};
    preferred  = mem[3][7];
    interlaced = mem[3][4];
    cfg_ok     = !interlaced && axis_ok(h_cfg) && axis_ok(v_cfg);
  end
endmodule

// File: rtl/vtg_axis_ctr.sv
module vtg_axis_ctr
  import vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  axis_cfg_t        cfg,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output logic             in_act,
  output logic             sync_lvl
);
  localparam int SUM_W = CNT_W + 2;

  logic [SUM_W-1:0] tot, s_beg, s_end;
  logic             in_sync;

  always_comb begin
    tot      = SUM_W'(cfg.act) + SUM_W'(cfg.blk);
    s_beg    = SUM_W'(cfg.act) + SUM_W'(cfg.fp);
    s_end    = s_beg + SUM_W'(cfg.sw);
    last     = (SUM_W'(cnt) == tot - SUM_W'(1));
    in_act   = (cnt < cfg.act);
    in_sync  = (SUM_W'(cnt) >= s_beg) && (SUM_W'(cnt) < s_end);
    sync_lvl = ~(in_sync ^ cfg.pos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt <= '0;
    else if (adv)       cnt <= last ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/desc_timing_gen.sv
module desc_timing_gen
  import vtg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_valid,
  output logic                    cfg_ready,
  input  logic [vtg_pkg::ADDR_W-1:0] cfg_addr,
  input  logic [7:0]              cfg_data,
  input  logic                    start,
  input  logic                    stop,
  output logic                    hsync,
  output logic                    vsync,
  output logic                    de,
  output logic [vtg_pkg::CNT_W-1:0] pix_x,
  output logic [vtg_pkg::CNT_W-1:0] line_y,
  output logic                    running,
  output logic                    desc_err,
  output logic [vtg_pkg::RATE_W-1:0] pixel_rate_khz,
  output logic                    preferred
);
  axis_cfg_t h_cfg, v_cfg;
  logic      cfg_ok;
  logic      run_q, err_q;
  logic      halt_now;
  logic      h_last, h_act, h_lvl;
  logic      v_last, v_act, v_lvl;

  vtg_desc_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_valid && !run_q),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_data),
    .h_cfg     (h_cfg),
    .v_cfg     (v_cfg),
    .rate      (pixel_rate_khz),
    .preferred (preferred),
    .cfg_ok    (cfg_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      err_q <= 1'b0;
    end else if (!run_q && start) begin
      run_q <= cfg_ok;
      err_q <= !cfg_ok;
    end else if (run_q && stop) begin
      run_q <= 1'b0;
    end
  end

  assign halt_now = !run_q || stop;

  vtg_axis_ctr u_hctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (halt_now),
    .adv      (run_q),
    .cfg      (h_cfg),
    .cnt      (pix_x),
    .last     (h_last),
    .in_act   (h_act),
    .sync_lvl (h_lvl)
  );

  vtg_axis_ctr u_vctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (halt_now),
    .adv      (run_q && h_last),
    .cfg      (v_cfg),
    .cnt      (line_y),
    .last     (v_last),
    .in_act   (v_act),
    .sync_lvl (v_lvl)
  );

  always_comb begin
    cfg_ready = !run_q;
    running   = run_q;
    desc_err  = err_q;
    de        = run_q && h_act && v_act;
    hsync     = run_q ? h_lvl : ~h_cfg.pos;
    vsync     = run_q ? v_lvl : ~v_cfg.pos;
  end
endmodule

// File: rtl/desc_timing_gen_chk.sv
module desc_timing_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic [4:0]  cfg_addr,
  input logic [7:0]  cfg_data,
  input logic        start,
  input logic        stop,
  input logic        hsync,
  input logic        vsync,
  input logic        de,
  input logic [15:0] pix_x,
  input logic [15:0] line_y,
  input logic        running,
  input logic        desc_err,
  input logic [23:0] pixel_rate_khz,
  input logic        preferred
);
  a_r7_de_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !de);

  a_r3_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (pix_x == 16'd0 && line_y == 16'd0));

  a_r4_pixel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && pix_x != 16'd0) |-> pix_x == $past(pix_x) + 16'd1);

  a_r4_line_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && line_y != $past(line_y)) |-> pix_x == 16'd0);

  a_r1_frozen_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(pixel_rate_khz));

  a_r8_reject_stays_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_err) |-> !running);

  a_r9_stop_to_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (running && stop) |=> (!running && pix_x == 16'd0 && line_y == 16'd0));
endmodule

bind desc_timing_gen desc_timing_gen_chk u_chk (.*);

// File: tb/test_desc_timing_gen.sv
module test_desc_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        hsync, vsync, de, running, desc_err, preferred;
  logic [15:0] pix_x, line_y;
  logic [23:0] pixel_rate_khz;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic        de, hs, vs;
    logic [15:0] x, y;
  } item_t;
  item_t exp_q[$];

  int ha, hb, hf, hw, hp, va, vb, vf, vw, vp;

  always #4 clk = ~clk;

  desc_timing_gen i_desc_timing_gen (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: sample 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (e !== {de, hsync, vsync, pix_x, line_y}) begin
        n_bad++;
        $display("FAIL R4/R5/R6/R7 actual de=%b hs=%b vs=%b x=%0d y=%0d expected de=%b hs=%b vs=%b x=%0d y=%0d",
                 de, hsync, vsync, pix_x, line_y, e.de, e.hs, e.vs, e.x, e.y);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = 5'(a); cfg_data = 8'(d);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wr16(input int a, input int v);
    wr(a, v & 255);
    wr(a + 1, (v >> 8) & 255);
  endtask

  task automatic load(input int rate, input int flags);
    wr(0, rate & 255); wr(1, (rate >> 8) & 255); wr(2, (rate >> 16) & 255);
    wr(3, flags);
    wr16(4, ha); wr16(6, hb); wr16(8, hf | (hp << 15)); wr16(10, hw);
    wr16(12, va); wr16(14, vb); wr16(16, vf | (vp << 15)); wr16(18, vw);
  endtask

  function automatic logic lvl(int c, int a, int f, int w, int p);
    logic in;
    in = (c >= a + f) && (c < a + f + w);
    return p ? in : !in;
  endfunction

  // driver: pulse start and push expected cycles for n running cycles
  task automatic run_cycles(input int n);
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k < n; k++) begin
      item_t e;
      int h, v;
      h = k % (ha + hb);
      v = (k / (ha + hb)) % (va + vb);
      e.x = 16'(h); e.y = 16'(v);
      e.de = (h < ha) && (v < va);
      e.hs = lvl(h, ha, hf, hw, hp);
      e.vs = lvl(v, va, vf, vw, vp);
      exp_q.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_stop();
    wait (exp_q.size() == 0);
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic try_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset running", running, 0);
    check("R7 reset de", de, 0);
    check("R1 reset ready", cfg_ready, 1);
    check("R10 reset err", desc_err, 0);

    // all-zero descriptor: zero active counts
    try_start();
    check("R8 zero active err", desc_err, 1);
    check("R8 zero active stopped", running, 0);

    // descriptor A: positive hsync, negative vsync, back porch present
    ha = 4; hb = 4; hf = 1; hw = 2; hp = 1;
    va = 3; vb = 3; vf = 1; vw = 1; vp = 0;
    load(24'h0123AB, 8'h80);
    check("R2 pixel rate", pixel_rate_khz, 24'h0123AB);
    check("R2 preferred", preferred, 1);
    check("R9 idle hsync", hsync, 0);
    check("R9 idle vsync", vsync, 1);

    run_cycles(2 * 48 + 5);
    @(negedge clk);
    check("R10 err cleared", desc_err, 0);
    check("R3 running", running, 1);
    check("R1 ready low", cfg_ready, 0);
    cfg_valid = 1'b1; cfg_addr = 5'd0; cfg_data = 8'hFF;
    @(negedge clk);
    cfg_valid = 1'b0;
    do_stop();
    check("R9 stopped", running, 0);
    check("R9 x origin", pix_x, 0);
    check("R9 y origin", line_y, 0);
    check("R9 de low", de, 0);
    check("R1 write ignored", pixel_rate_khz, 24'h0123AB);

    // descriptor B: no front porch, no back porch, swapped polarities
    ha = 5; hb = 3; hf = 0; hw = 3; hp = 0;
    va = 2; vb = 2; vf = 0; vw = 2; vp = 1;
    load(24'h00BEEF, 8'h00);
    check("R2 preferred clear", preferred, 0);
    check("R9 idle hsync B", hsync, 1);
    check("R9 idle vsync B", vsync, 0);
    run_cycles(3 * 32 + 3);
    do_stop();

    // rejections
    wr(3, 8'h10);
    try_start();
    check("R8 interlaced err", desc_err, 1);
    check("R8 interlaced stopped", running, 0);
    wr(3, 8'h00);
    wr16(10, 4);
    try_start();
    check("R8 h porch+sync over blank", desc_err, 1);
    check("R8 h overflow stopped", running, 0);
    wr16(10, 3);
    wr16(18, 3);
    try_start();
    check("R8 v porch+sync over blank", desc_err, 1);
    wr16(18, 2);
    wr16(12, 0);
    try_start();
    check("R8 v active zero", desc_err, 1);
    check("R8 v active zero stopped", running, 0);
    wr16(12, 2);
    run_cycles(20);
    do_stop();
    check("R10 err cleared again", desc_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule